// File: doc/BRIEF.md
# Energy-Steered Decimation Phase Selector

This block sits between an interpolation filter and the point where an I/Q stream is reduced by an integer factor D. It does not always keep phase zero of each group of D samples. Instead, it measures the energy I²+Q² that arrives at every phase offset over an observation window of a programmable number of groups. When the window closes, it adopts the phase that carried the most energy. It then keeps that phase until the next window closes. Sampling at a phase that is not aligned with the original samples distorts the recovered signal. Following the energy lets the decimator return to the aligned samples after timing has slipped.

A second mode replaces single-phase picking with the mean of each group. In that mode the energy measurement and the phase tracking keep running, so the reported phase stays current. The factor D, the window length and the mode are plain inputs, and the system above this block holds them steady.

Top module: `energy_phase_decim`

## Requirements
- R1: After reset, `out_valid` and `phase_upd` are 0 and `phase_sel` is 0.
- R2: Accepted samples are numbered from 0 after reset. Sample k sits at phase k mod D. The effective D is 1 when `dec_factor` is 0, 16 when `dec_factor` exceeds 16, and `dec_factor` otherwise.
- R3: With `avg_mode`=0, a sample is forwarded only if its phase equals the current `phase_sel`. It appears on `out_i`/`out_q` with `out_valid`=1 in the cycle after it was accepted, so each group yields exactly one output.
- R4: Each window spans W groups, where W is `win_groups`, or 1 when `win_groups` is 0. When the last sample of a window is accepted, `phase_sel` becomes the phase below D with the largest sum of I²+Q² over that window. The new value is visible in the following cycle.
- R5: When several phases share the largest energy, the lowest phase index is selected.
- R6: `phase_sel` changes only at a window close. `phase_upd` is 1 for exactly the cycle in which the new value from a window close first shows, and it pulses at every close, even if the phase stays the same.
- R7: The energy of one window has no influence on the choice made at the end of the next window.
- R8: With `avg_mode`=1, each group yields one output in the cycle after its last sample. The output is the sum of the group's I (and Q) samples divided by D, truncated toward zero.
- R9: With D=1 and `avg_mode`=0, every accepted sample is forwarded unchanged one cycle later, and `phase_sel` stays 0.
- R10: `out_valid` and `phase_upd` are 1 only in a cycle that follows a cycle with `in_valid`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_factor | input | 5 | Decimation factor D (clamped to 1..16) |
| win_groups | input | 8 | Groups per observation window (0 means 1) |
| avg_mode | input | 1 | 1: output group mean, 0: output the selected phase |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 12 | Filtered in-phase sample, signed |
| in_q | input | 12 | Filtered quadrature sample, signed |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | 12 | Decimated in-phase sample, signed |
| out_q | output | 12 | Decimated quadrature sample, signed |
| phase_sel | output | 4 | Phase index currently used for decimation |
| phase_upd | output | 1 | One-cycle pulse on each window close |

## Verification
The hardest situations to reach from the ports are a tie between phases and a window whose winner would differ if the previous window's energy had carried over. Only a window close exposes the internal energies, and only through `phase_sel`. Directed sequences handle both. One window drives `phase_sel` away from zero with a strong phase, and the next feeds equal energy on every phase, which must bring the selection back to zero. Another pair puts a very large energy on one phase and then a small energy on a different phase. Random segments vary D (including the clamped values 0 and 20), the window length, gaps in `in_valid` and a biased phase. A bench model tracks every output cycle during these segments.

// File: rtl/energy_phase_decim.sv
module energy_phase_decim #(
  parameter int W    = 12,
  parameter int DMAX = 16,
  parameter int WINW = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [$clog2(DMAX):0]     dec_factor,
  input  logic [WINW-1:0]           win_groups,
  input  logic                      avg_mode,
  input  logic                      in_valid,
  input  logic signed [W-1:0]       in_i,
  input  logic signed [W-1:0]       in_q,
  output logic                      out_valid,
  output logic signed [W-1:0]       out_i,
  output logic signed [W-1:0]       out_q,
  output logic [$clog2(DMAX)-1:0]   phase_sel,
  output logic                      phase_upd
);

  localparam int PW   = $clog2(DMAX);
  localparam int DW   = PW + 1;
  localparam int EW   = 2 * W + 1;
  localparam int ACCW = EW + WINW;
  localparam int SW   = W + PW + 1;

  logic [DW-1:0]   d_eff;
  logic [WINW-1:0] w_last;
  logic [PW-1:0]   ph;
  logic [WINW-1:0] grp;
  logic            grp_last;
  logic            win_close;

  assign d_eff = (dec_factor == '0) ? DW'(1) :
                 (dec_factor > DW'(DMAX)) ? DW'(DMAX) : dec_factor;
  assign w_last    = (win_groups == '0) ? '0 : win_groups - WINW'(1);
  assign grp_last  = ({1'b0, ph} >= d_eff - DW'(1));
  assign win_close = in_valid && grp_last && (grp == w_last);

  // per-sample energy
  logic signed [2*W-1:0] sq_i, sq_q;
  logic [EW-1:0]         energy;
  assign sq_i   = in_i * in_i;
  assign sq_q   = in_q * in_q;
  assign energy = EW'($unsigned(sq_i)) + EW'($unsigned(sq_q));

  // energy accumulators, one per phase
  logic [ACCW-1:0] acc  [DMAX];
  logic [ACCW-1:0] nacc [DMAX];

  always_comb begin
    for (int p = 0; p < DMAX; p++) begin
      nacc[p] = acc[p];
      if (in_valid && ph == PW'(p)) nacc[p] = acc[p] + ACCW'(energy);
    end
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < DMAX; p++) begin
      if (!rst_n || win_close) acc[p] <= '0;
      else acc[p] <= nacc[p];
    end
  end

  // strict-greater scan: lowest index wins ties
  logic [PW-1:0]   best;
  logic [ACCW-1:0] best_e;
  always_comb begin
    best   = '0;
    best_e = nacc[0];
    for (int p = 1; p < DMAX; p++) begin
      if (DW'(p) < d_eff && nacc[p] > best_e) begin
        best   = PW'(p);
        best_e = nacc[p];
      end
    end
  end

  // group sums for averaging
  logic signed [SW-1:0] sum_i, sum_q, tot_i, tot_q, avg_i, avg_q, div;
  assign tot_i = sum_i + SW'(in_i);
  assign tot_q = sum_q + SW'(in_q);
  assign div   = $signed(SW'(d_eff));
  assign avg_i = tot_i / div;
  assign avg_q = tot_q / div;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph        <= '0;
      grp       <= '0;
      sum_i     <= '0;
      sum_q     <= '0;
      phase_sel <= '0;
      phase_upd <= 1'b0;
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      phase_upd <= win_close;
      out_valid <= 1'b0;
      if (in_valid) begin
        if (avg_mode) begin
          if (grp_last) begin
            out_valid <= 1'b1;
            out_i     <= W'(avg_i);
            out_q     <= W'(avg_q);
          end
        end else if (ph == phase_sel) begin
          out_valid <= 1'b1;
          out_i     <= in_i;
          out_q     <= in_q;
        end
        if (grp_last) begin
          ph    <= '0;
          sum_i <= '0;
          sum_q <= '0;
          if (win_close) begin
            grp       <= '0;
            phase_sel <= best;
          end else begin
            grp <= grp + WINW'(1);
          end
        end else begin
          ph    <= ph + PW'(1);
          sum_i <= tot_i;
          sum_q <= tot_q;
        end
      end
    end
  end

endmodule

// File: rtl/energy_phase_decim_chk.sv
module energy_phase_decim_chk #(
  parameter int W    = 12,
  parameter int DMAX = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [$clog2(DMAX):0]   dec_factor,
  input logic                    avg_mode,
  input logic                    in_valid,
  input logic signed [W-1:0]     in_i,
  input logic                    out_valid,
  input logic signed [W-1:0]     out_i,
  input logic [$clog2(DMAX)-1:0] phase_sel,
  input logic                    phase_upd
);
  localparam int DW = $clog2(DMAX) + 1;

  logic [DW-1:0] d_lim;
  assign d_lim = (dec_factor == '0) ? DW'(1) :
                 (dec_factor > DW'(DMAX)) ? DW'(DMAX) : dec_factor;

  p_sel_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(phase_sel) |-> phase_upd);

  p_upd_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    phase_upd |-> $past(in_valid));

  p_out_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  p_sel_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    phase_upd |-> ({1'b0, phase_sel} < $past(d_lim)));

  p_pass_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_valid) && $past(d_lim) == DW'(1) && !$past(avg_mode))
      |-> (out_valid && out_i == $past(in_i)));
endmodule

bind energy_phase_decim energy_phase_decim_chk #(.W(W), .DMAX(DMAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .dec_factor(dec_factor), .avg_mode(avg_mode),
  .in_valid(in_valid), .in_i(in_i), .out_valid(out_valid), .out_i(out_i),
  .phase_sel(phase_sel), .phase_upd(phase_upd)
);

// File: tb/tb_energy_phase_decim.sv
module tb_energy_phase_decim;
  localparam int CLK_NS = 10;
  localparam int W = 12;

  logic clk = 0, rst_n = 0;
  logic [4:0] dec_factor = 5'd4;
  logic [7:0] win_groups = 8'd1;
  logic avg_mode = 0, in_valid = 0;
  logic signed [W-1:0] in_i = '0, in_q = '0;
  logic out_valid, phase_upd;
  logic signed [W-1:0] out_i, out_q;
  logic [3:0] phase_sel;

  energy_phase_decim dut (
    .clk(clk), .rst_n(rst_n), .dec_factor(dec_factor), .win_groups(win_groups),
    .avg_mode(avg_mode), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q),
    .phase_sel(phase_sel), .phase_upd(phase_upd));

  always #(CLK_NS/2) clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: act=%0d exp=<150000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(bit ok, string tag, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // bench model state
  int cfg_d, cfg_w;
  bit cfg_avg;
  int m_ph, m_grp, m_sel;
  longint m_acc[16];
  longint m_si, m_sq;
  bit e_ov, e_upd;
  longint e_oi, e_oq;

  function automatic int eff_d(int d);
    return (d == 0) ? 1 : (d > 16 ? 16 : d);
  endfunction

  function automatic void model_clear();
    m_ph = 0; m_grp = 0; m_sel = 0; m_si = 0; m_sq = 0;
    foreach (m_acc[p]) m_acc[p] = 0;
  endfunction

  function automatic void model_step(bit v, int i, int q);
    int d, w, best;
    d = eff_d(cfg_d);
    w = (cfg_w == 0) ? 1 : cfg_w;
    e_ov = 0; e_upd = 0;
    if (!v) return;
    m_acc[m_ph] += longint'(i) * i + longint'(q) * q;
    if (!cfg_avg && m_ph == m_sel) begin
      e_ov = 1; e_oi = i; e_oq = q;
    end
    m_si += i; m_sq += q;
    if (m_ph >= d - 1) begin
      if (cfg_avg) begin
        e_ov = 1; e_oi = m_si / d; e_oq = m_sq / d;
      end
      m_si = 0; m_sq = 0;
      if (m_grp == w - 1) begin
        best = 0;
        for (int p = 1; p < d; p++) if (m_acc[p] > m_acc[best]) best = p;
        m_sel = best; e_upd = 1; m_grp = 0;
        foreach (m_acc[p]) m_acc[p] = 0;
      end else m_grp++;
      m_ph = 0;
    end else m_ph++;
  endfunction

  task automatic config_reset(int d, int w, bit avg);
    cfg_d = d; cfg_w = w; cfg_avg = avg;
    @(negedge clk);
    rst_n = 0; in_valid = 0;
    dec_factor = 5'(d); win_groups = 8'(w); avg_mode = avg;
    repeat (2) @(negedge clk);
    rst_n = 1;
    model_clear();
    chk(out_valid == 0, "R1 out_valid", out_valid, 0);
    chk(phase_upd == 0, "R1 phase_upd", phase_upd, 0);
    chk(phase_sel == 0, "R1 phase_sel", phase_sel, 0);
  endtask

  task automatic step(bit v, int i, int q);
    in_valid = v; in_i = W'(i); in_q = W'(q);
    model_step(v, i, q);
    @(negedge clk);
    chk(out_valid == e_ov, "R3 R8 R9 R10 out_valid", out_valid, e_ov);
    if (e_ov) begin
      chk(longint'(out_i) == e_oi, "R2 R3 R8 out_i", out_i, e_oi);
      chk(longint'(out_q) == e_oq, "R2 R3 R8 out_q", out_q, e_oq);
    end
    chk(phase_upd == e_upd, "R6 R10 phase_upd", phase_upd, e_upd);
    chk(int'(phase_sel) == m_sel, "R4 R6 phase_sel", phase_sel, m_sel);
  endtask

  // one group; phase 'hot' gets amplitude a_hot, others a_cold
  task automatic group(int d, int hot, int a_hot, int a_cold);
    for (int p = 0; p < d; p++) step(1, (p == hot) ? a_hot : a_cold, 0);
  endtask

  initial begin
    // R2/R3: ramp with D=4, phase 0 kept at first
    config_reset(4, 3, 0);
    for (int k = 0; k < 12; k++) step(1, k, -k);
    // R4: phase 2 dominant
    config_reset(4, 2, 0);
    group(4, 2, 1000, 10);
    group(4, 2, 1000, 10);
    chk(phase_sel == 2, "R4 strong phase", phase_sel, 2);
    for (int k = 0; k < 8; k++) step(1, 100 + k, k);
    // R5: move away from 0, then equal energies must return 0
    config_reset(3, 1, 0);
    group(3, 2, 500, 0);
    chk(phase_sel == 2, "R5 setup", phase_sel, 2);
    group(3, 0, 100, 100);
    chk(phase_sel == 0, "R5 tie lowest", phase_sel, 0);
    // R7: huge phase-1 window, then small phase-3 window
    config_reset(5, 1, 0);
    group(5, 1, 2000, 0);
    chk(phase_sel == 1, "R7 setup", phase_sel, 1);
    group(5, 3, 50, 0);
    chk(phase_sel == 3, "R7 window cleared", phase_sel, 3);
    // R9: D=1 pass-through
    config_reset(1, 2, 0);
    for (int k = 0; k < 20; k++)
      step($urandom_range(1, 0), $urandom_range(4095, 0) - 2048, $urandom_range(4095, 0) - 2048);
    chk(phase_sel == 0, "R9 phase stays 0", phase_sel, 0);
    // R8: averaging with negatives
    config_reset(5, 2, 1);
    for (int k = 0; k < 40; k++)
      step(1, $urandom_range(4095, 0) - 2048, $urandom_range(200, 0) - 100);
    // R4: window length 0 acts as 1
    config_reset(2, 0, 0);
    group(2, 1, 300, 1);
    chk(phase_sel == 1, "R4 window 0 as 1", phase_sel, 1);
    // random configurations including clamped D values 0 and 20
    for (int t = 0; t < 24; t++) begin
      int d, hot, amp;
      d = (t == 3) ? 0 : (t == 5) ? 20 : $urandom_range(16, 1);
      config_reset(d, $urandom_range(4, 0), (t % 4 == 3));
      hot = $urandom_range(eff_d(d) - 1, 0);
      for (int k = 0; k < 300; k++) begin
        amp = (m_ph == hot) ? 1500 : 300;
        step($urandom_range(3, 0) != 0,
             $urandom_range(2 * amp, 0) - amp, $urandom_range(2 * amp, 0) - amp);
      end
    end
    in_valid = 0;
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    process::self().srandom(32'd12345);
  end
endmodule